// File: doc/BRIEF.md
# Reorder-tolerant thermometer-to-binary encoder

This block turns the raw decisions of four interleaved flash comparator arrays into 6-bit binary samples. Each array has 69 comparators: 63 in the working range and three spares at each end. Calibration can re-sort the array, so the comparator that switches at a given input level need not sit at the matching physical index. The encoder therefore does not search for a 1-to-0 edge. It counts the enabled comparators that read high with an adder tree. The code then depends only on how many comparators fired, not on which ones, and a count can only rise as more comparators switch.

Every comparator bit first passes through a three-register synchronizer. A per-interleave enable mask then selects which comparators take part in the count. The counts are right-shifted when a reduced resolution is selected. Each clock brings one sample from every interleave. The block packs four clocks of samples into one 16-sample word and raises a one-cycle strobe with that word, so the output rate is one sixteenth of the aggregate sample rate. Firmware loads new masks over a small write port. A new mask, and a new resolution setting, take effect only where one output word ends and the next begins.

Top module: `therm_count_encoder`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and data_o is zero. Reset enables comparators 3 to 65 on every interleave and selects full resolution.
- R2: Each sample equals the number of enabled comparators whose input is high, whatever their positions in the array. Comparator c of interleave i is cmp_i bit i*69+c.
- R3: The synchronizer adds three register stages. The last sample of a word, captured at clock edge e, appears on data_o after edge e+3. The first input captured after reset is slot 0 of the first word.
- R4: A comparator whose mask bit is 0 adds nothing to the count, whatever its input.
- R5: A count above 63 saturates to 63.
- R6: res_mode_i value 0 gives the count unchanged. Value 1 gives the count shifted right by one (5-bit). Values 2 and 3 give the count shifted right by two (4-bit). Each result is right-aligned in its 6-bit field.
- R7: The field for time slot s (0 = oldest) and interleave i lies at data_o bits [(4*s+i)*6 +: 6].
- R8: valid_o is a one-cycle pulse. The first pulse follows the 7th clock edge after reset, and a pulse follows every 4th edge after that. data_o changes only with a pulse.
- R9: mask_wr_i stores mask_data_i as the pending mask of the interleave that mask_sel_i names. A pending mask becomes active at the next boundary edge, which is any of the first three edges after reset or any edge that completes a word. A write captured on a boundary edge waits for the following boundary. A word is therefore never encoded with two masks.
- R10: res_mode_i is sampled only at boundary edges, and the sampled value governs every slot of the following word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock, one sample per interleave per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmp_i | input | 276 | Raw comparator decisions, 69 per interleave |
| mask_wr_i | input | 1 | Write strobe for a pending enable mask |
| mask_sel_i | input | 2 | Interleave the write targets |
| mask_data_i | input | 69 | Enable mask to store, bit c enables comparator c |
| res_mode_i | input | 2 | Resolution select, sampled at boundaries |
| data_o | output | 96 | Packed word of 16 six-bit samples |
| valid_o | output | 1 | One-cycle strobe marking a new word |

## Verification
The hardest case to reach is a mask write or a resolution change that lands in the middle of a word, or on the very edge that completes one. Such a change must not leak into the word in flight, and a write on a completing edge must wait a whole extra word. The bench issues writes at each slot position of a word and changes res_mode_i mid-word. It follows the pending and active state edge by edge, so every word must match a single mask and mode. Shuffled thermometer levels, with a different permutation of set bits per interleave, check that only the number of firing comparators matters.

// File: rtl/tce_pkg.sv
package tce_pkg;
  localparam logic [1:0] RES_FULL = 2'd0;
  localparam logic [1:0] RES_HALF = 2'd1;
endpackage

// File: rtl/tce_sync.sv
module tce_sync #(
  parameter int unsigned WIDTH  = 69,
  parameter int unsigned STAGES = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] pipe_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) pipe_q[k] <= '0;
    end else begin
      pipe_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) pipe_q[k] <= pipe_q[k-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/tce_count.sv
module tce_count
  import tce_pkg::*;
#(
  parameter int unsigned NUM_CMP = 69,
  parameter int unsigned CODE_W  = 6
) (
  input  logic [NUM_CMP-1:0] bits_i,
  input  logic [NUM_CMP-1:0] mask_i,
  input  logic [1:0]         mode_i,
  output logic [CODE_W-1:0]  code_o
);
  localparam int unsigned CNT_W  = $clog2(NUM_CMP + 1);
  localparam int unsigned LVLS   = $clog2(NUM_CMP);
  localparam int unsigned LEAVES = 1 << LVLS;
  localparam logic [CNT_W-1:0] CODE_MAX = CNT_W'((1 << CODE_W) - 1);

  logic [NUM_CMP-1:0] live;
  logic [CNT_W-1:0]   cnt;
  logic [CODE_W-1:0]  sat;

  assign live = bits_i & mask_i;

  // balanced adder tree, leaves padded with zero
  for (genvar l = 0; l <= LVLS; l++) begin : lv
    logic [CNT_W-1:0] s [LEAVES >> l];
    for (genvar n = 0; n < (LEAVES >> l); n++) begin : nd
      if (l == 0) begin : leaf
        if (n < NUM_CMP) begin : used
          assign s[n] = CNT_W'(live[n]);
        end else begin : pad
          assign s[n] = '0;
        end
      end else begin : add
        assign s[n] = lv[l-1].s[2*n] + lv[l-1].s[2*n+1];
      end
    end
  end

  assign cnt = lv[LVLS].s[0];
  assign sat = (cnt > CODE_MAX) ? CODE_MAX[CODE_W-1:0] : cnt[CODE_W-1:0];

  always_comb begin
    case (mode_i)
      RES_FULL: code_o = sat;
      RES_HALF: code_o = sat >> 1;
      default:  code_o = sat >> 2;
    endcase
  end
endmodule

// File: rtl/tce_mask_ctl.sv
module tce_mask_ctl #(
  parameter int unsigned NUM_IL  = 4,
  parameter int unsigned NUM_CMP = 69,
  parameter logic [NUM_CMP-1:0] RST_MASK = '1,
  localparam int unsigned IL_W   = (NUM_IL > 1) ? $clog2(NUM_IL) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_i,
  input  logic [IL_W-1:0]           sel_i,
  input  logic [NUM_CMP-1:0]        data_i,
  input  logic [1:0]                mode_i,
  input  logic                      apply_i,
  output logic [NUM_IL*NUM_CMP-1:0] mask_o,
  output logic [1:0]                mode_o
);
  logic [NUM_IL*NUM_CMP-1:0] pend_q;
  logic [NUM_IL-1:0]         pend_vld_q;

  for (genvar i = 0; i < NUM_IL; i++) begin : g_il
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_o[i*NUM_CMP +: NUM_CMP] <= RST_MASK;
        pend_q[i*NUM_CMP +: NUM_CMP] <= '0;
        pend_vld_q[i]                <= 1'b0;
      end else begin
        if (apply_i && pend_vld_q[i]) mask_o[i*NUM_CMP +: NUM_CMP] <= pend_q[i*NUM_CMP +: NUM_CMP];
        // a write on a boundary edge stays pending for the next boundary
        if (wr_i && sel_i == IL_W'(i)) begin
          pend_q[i*NUM_CMP +: NUM_CMP] <= data_i;
          pend_vld_q[i]                <= 1'b1;
        end else if (apply_i) begin
          pend_vld_q[i]                <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_o <= '0;
    else if (apply_i) mode_o <= mode_i;
  end

  // R9
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apply_i |=> $stable(mask_o));

  // R10
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apply_i |=> $stable(mode_o));
endmodule

// File: rtl/therm_count_encoder.sv
module therm_count_encoder
  import tce_pkg::*;
#(
  parameter int unsigned NUM_ACTIVE  = 63,
  parameter int unsigned NUM_SPARE   = 3,
  parameter int unsigned NUM_IL      = 4,
  parameter int unsigned SLOTS       = 4,
  parameter int unsigned SYNC_STAGES = 3,
  parameter int unsigned CODE_W      = 6,
  localparam int unsigned NUM_CMP    = NUM_ACTIVE + 2 * NUM_SPARE,
  localparam int unsigned IL_W       = (NUM_IL > 1) ? $clog2(NUM_IL) : 1,
  localparam int unsigned GRP_W      = NUM_IL * CODE_W,
  localparam int unsigned WORD_W     = SLOTS * GRP_W,
  localparam int unsigned LATENCY    = SYNC_STAGES
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_IL*NUM_CMP-1:0] cmp_i,
  input  logic                      mask_wr_i,
  input  logic [IL_W-1:0]           mask_sel_i,
  input  logic [NUM_CMP-1:0]        mask_data_i,
  input  logic [1:0]                res_mode_i,
  output logic [WORD_W-1:0]         data_o,
  output logic                      valid_o
);
  localparam int unsigned SLOT_W = $clog2(SLOTS);
  localparam logic [NUM_CMP-1:0] RST_MASK =
    ({NUM_CMP{1'b1}} >> (NUM_CMP - NUM_ACTIVE)) << NUM_SPARE;

  logic [NUM_IL*NUM_CMP-1:0] synced;
  logic [NUM_IL*NUM_CMP-1:0] mask_act;
  logic [1:0]                mode_act;
  logic [GRP_W-1:0]          codes;
  logic [LATENCY-1:0]        fill_q;
  logic                      fill_done;
  logic [SLOT_W-1:0]         slot_q;
  logic                      last_slot;
  logic                      apply;
  logic [(SLOTS-1)*GRP_W-1:0] hold_q;

  for (genvar i = 0; i < NUM_IL; i++) begin : g_lane
    tce_sync #(.WIDTH(NUM_CMP), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (cmp_i[i*NUM_CMP +: NUM_CMP]),
      .q_o    (synced[i*NUM_CMP +: NUM_CMP])
    );
    tce_count #(.NUM_CMP(NUM_CMP), .CODE_W(CODE_W)) u_count (
      .bits_i (synced[i*NUM_CMP +: NUM_CMP]),
      .mask_i (mask_act[i*NUM_CMP +: NUM_CMP]),
      .mode_i (mode_act),
      .code_o (codes[i*CODE_W +: CODE_W])
    );
  end

  // marks when the synchronizer holds real samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fill_q <= '0;
    else         fill_q <= {fill_q[LATENCY-2:0], 1'b1};
  end
  assign fill_done = fill_q[LATENCY-1];
  assign last_slot = fill_done && (slot_q == SLOT_W'(SLOTS - 1));
  assign apply     = !fill_done || last_slot;

  tce_mask_ctl #(.NUM_IL(NUM_IL), .NUM_CMP(NUM_CMP), .RST_MASK(RST_MASK)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (mask_wr_i),
    .sel_i   (mask_sel_i),
    .data_i  (mask_data_i),
    .mode_i  (res_mode_i),
    .apply_i (apply),
    .mask_o  (mask_act),
    .mode_o  (mode_act)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q  <= '0;
      hold_q  <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= last_slot;
      if (fill_done) begin
        if (last_slot) begin
          slot_q <= '0;
          data_o <= {codes, hold_q};
        end else begin
          slot_q <= slot_q + 1'b1;
          hold_q[int'(slot_q)*GRP_W +: GRP_W] <= codes;
        end
      end
    end
  end

  logic codes_small;
  always_comb begin
    codes_small = 1'b1;
    for (int i = 0; i < NUM_IL; i++)
      if (codes[i*CODE_W +: CODE_W] >= CODE_W'(1 << (CODE_W - 2))) codes_small = 1'b0;
  end

  // R8
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R8
  valid_after_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> fill_done);

  // R6
  low_res_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_done && mode_act[1]) |-> codes_small);
endmodule

// File: tb/therm_count_encoder_bench.sv
module therm_count_encoder_bench;
  localparam int NC = 69;
  localparam int NIL = 4;
  localparam int VW = NC * NIL;
  localparam int DW = 96;
  localparam logic [NC-1:0] RST_MASK = {3'b000, {63{1'b1}}, 3'b000};

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [VW-1:0] cmp = '0;
  logic          mask_wr = 1'b0;
  logic [1:0]    mask_sel = '0;
  logic [NC-1:0] mask_data = '0;
  logic [1:0]    res_mode = '0;
  logic [DW-1:0] data_o;
  logic          valid_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  therm_count_encoder u_therm_count_encoder (
    .clk_i (clk), .rst_ni (rst_ni), .cmp_i (cmp),
    .mask_wr_i (mask_wr), .mask_sel_i (mask_sel), .mask_data_i (mask_data),
    .res_mode_i (res_mode), .data_o (data_o), .valid_o (valid_o)
  );

  // bench model, built from the requirements
  int            e;
  logic [VW-1:0] h1, h2, h3;
  logic [NC-1:0] act [NIL];
  logic [NC-1:0] pend [NIL];
  bit            pflag [NIL];
  logic [1:0]    amode;
  logic [DW-1:0] ew;

  task automatic check_eq(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    e = 0; h1 = '0; h2 = '0; h3 = '0; ew = '0; amode = 2'd0;
    for (int i = 0; i < NIL; i++) begin
      act[i] = RST_MASK; pend[i] = '0; pflag[i] = 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; cmp = '0; mask_wr = 1'b0; res_mode = 2'd0;
    @(negedge clk);
    // R1
    check_eq("R1 valid in reset", DW'(valid_o), '0);
    check_eq("R1 data in reset", data_o, '0);
    model_reset();
    rst_ni = 1'b1;
  endtask

  // one clock edge: drive, predict, then compare at the following negedge
  task automatic step(input string tag, input logic [VW-1:0] x, input bit wr,
                      input logic [1:0] sel, input logic [NC-1:0] md, input logic [1:0] mode);
    bit            exp_v;
    bit            apply;
    logic [DW-1:0] exp_d;
    int            slot;
    int            cnt;
    cmp = x; mask_wr = wr; mask_sel = sel; mask_data = md; res_mode = mode;
    e++;
    exp_v = 0; exp_d = '0;
    if (e >= 4) begin
      slot = (e - 4) % 4;
      for (int i = 0; i < NIL; i++) begin
        cnt = $countones(h3[i*NC +: NC] & act[i]);
        if (cnt > 63) cnt = 63;
        if (amode == 2'd1) cnt = cnt >> 1;
        else if (amode[1]) cnt = cnt >> 2;
        ew[(slot*4 + i)*6 +: 6] = 6'(cnt);
      end
      if (slot == 3) begin exp_v = 1; exp_d = ew; end
    end
    apply = (e <= 3) || ((e - 4) % 4 == 3);
    if (apply) begin
      for (int i = 0; i < NIL; i++) if (pflag[i]) act[i] = pend[i];
      amode = mode;
    end
    for (int i = 0; i < NIL; i++) begin
      if (wr && sel == 2'(i)) begin pend[i] = md; pflag[i] = 1; end
      else if (apply) pflag[i] = 0;
    end
    h3 = h2; h2 = h1; h1 = x;
    @(posedge clk);
    @(negedge clk);
    // R8
    checks++;
    if (valid_o !== exp_v) begin
      failures++;
      $display("FAIL R8 valid at edge %0d: got %0b expected %0b", e, valid_o, exp_v);
    end
    if (exp_v) check_eq(tag, data_o, exp_d);
  endtask

  function automatic logic [VW-1:0] therm(input int k, input int seed);
    logic [VW-1:0] v;
    int ki;
    v = '0;
    for (int i = 0; i < NIL; i++) begin
      ki = (k + i * 5) % 70;
      for (int c = 0; c < NC; c++)
        v[i*NC + c] = (((c * 7 + i * 13 + seed) % NC) < ki);
    end
    return v;
  endfunction

  function automatic logic [VW-1:0] rnd();
    logic [VW-1:0] v;
    for (int b = 0; b < VW; b++) v[b] = 1'($urandom_range(1, 0));
    return v;
  endfunction

  function automatic logic [NC-1:0] span(input int lo, input int n);
    return ({NC{1'b1}} >> (NC - n)) << lo;
  endfunction

  initial begin
    logic [NC-1:0] evens;
    logic [NC-1:0] odds;
    for (int c = 0; c < NC; c++) begin evens[c] = (c % 2 == 0); odds[c] = (c % 2 == 1); end
    model_reset();
    do_reset();

    // shuffled thermometer levels, default mask
    for (int k = 0; k < 70; k++)
      for (int s = 0; s < 4; s++)
        step("R1 R2 R3 R7 levels", therm(k, s * 11 + k), 0, 0, '0, 2'd0);
    for (int w = 0; w < 40; w++)
      for (int s = 0; s < 4; s++)
        step("R2 random", rnd(), 0, 0, '0, 2'd0);

    // all 69 enabled, saturation
    for (int i = 0; i < NIL; i++) step("R5 setup", '1, 1, 2'(i), '1, 2'd0);
    for (int w = 0; w < 24; w++)
      for (int s = 0; s < 4; s++)
        step("R5 saturate", (w % 3 == 0) ? '1 : therm(58 + w % 12, s), 0, 0, '0, 2'd0);

    // distinct masks written mid-word and on completing edges
    step("R4 R9 mask", rnd(), 1, 2'd0, evens, 2'd0);
    step("R4 R9 mask", rnd(), 1, 2'd1, odds, 2'd0);
    step("R4 R9 mask", rnd(), 1, 2'd2, span(0, 20), 2'd0);
    step("R4 R9 mask", rnd(), 1, 2'd3, '0, 2'd0);
    for (int w = 0; w < 20; w++)
      for (int s = 0; s < 4; s++) begin
        if (s == w % 4) step("R4 R9 mask", rnd(), 1, 2'(w % 4), span(w % 30, 9 + w), 2'd0);
        else            step("R4 R9 mask", (w % 2 == 1) ? '1 : rnd(), 0, 0, '0, 2'd0);
      end

    // reduced resolution, mode changed mid-word
    for (int i = 0; i < NIL; i++) step("R6 R10 setup", rnd(), 1, 2'(i), span(19, 31), 2'd1);
    for (int w = 0; w < 18; w++)
      for (int s = 0; s < 4; s++)
        step("R6 R10 five-bit", therm(w * 4 + s, w), 0, 0, '0, (w == 17 && s == 2) ? 2'd2 : 2'd1);
    for (int i = 0; i < NIL; i++) step("R6 R10 setup", rnd(), 1, 2'(i), span(27, 15), 2'd2);
    for (int w = 0; w < 18; w++)
      for (int s = 0; s < 4; s++)
        step("R6 R10 four-bit", (s == 1) ? rnd() : therm(w * 4 + s, s), 0, 0, '0, (w >= 9) ? 2'd3 : 2'd2);

    // reset in the middle of a word
    step("R8 partial", rnd(), 0, 0, '0, 2'd0);
    step("R8 partial", rnd(), 0, 0, '0, 2'd0);
    do_reset();
    for (int w = 0; w < 6; w++)
      for (int s = 0; s < 4; s++)
        step("R1 R3 after reset", therm(w * 10 + s, w), 0, 0, '0, 2'd0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule